// File: doc/BRIEF.md
# Link Activity Sync Detector

This block decides whether a recovered video link is alive by watching its data-enable strobe. It turns a noisy or absent enable waveform into one steady flag. The flag goes high once the enable has shown a short, unbroken run of rising edges. It goes low only after the enable has stayed at one level for a long, configurable number of pixel clocks, typically about a millisecond. A transmitter that has powered down is therefore just a longer quiet interval and needs no special handling.

The flag can blank a pixel output formatter that has no useful data to show. It can also serve as the single/dual-link indicator for a partner receiver. No output-disable control gates the flag, so it stays valid while the outputs it controls are off. A full power-down input clears the decision at once.

The enable is resynchronised through `SYNC_STAGES` flops (default 2) before edge detection. Rising edges are counted toward `EDGES_TO_LOCK` (N, default 4). A saturating idle counter measures pixel clocks since the last edge of either polarity against `TIMEOUT_CYCLES` (T).

Top module: `link_activity_detector`

## Requirements
- R1: While `rst_n` is low, and in the cycles after its release with no enable activity, `link_alive` is 0.
- R2: With 2 sync stages, `link_alive` becomes 1 exactly 3 clock cycles after the input change that forms the N-th qualifying rising edge, and not 2 cycles after it.
- R3: Fewer than N rising edges, followed by a static enable, never raise `link_alive`.
- R4: A rising edge that arrives T+1 or more cycles after the previous enable edge starts a new run with a count of 1. A rising edge that arrives T cycles after it continues the current run.
- R5: Once `link_alive` is 1 and the enable stops changing at either level, the flag stays 1 for T+3 cycles after the last input change and is 0 in cycle T+4.
- R6: The idle counter saturates at T and never wraps, so a static enable of any length keeps `link_alive` at 0.
- R7: `pwr_down` = 1 clears the flag, the edge count and the idle counter at the next clock edge. While it is held, no edge counts. After release, N fresh rising edges are needed.
- R8: Falling edges count as activity. A waveform whose rising edges are more than T cycles apart, but whose every edge is less than T cycles from the previous one, keeps `link_alive` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Full power-down; synchronously clears the detector when 1 |
| de_in | input | 1 | Recovered data-enable strobe, asynchronous to `clk` |
| link_alive | output | 1 | Sync-detect flag; 1 while the enable is toggling |

## Verification
A wrong edge count shows up as a lock that is one rising edge early or late. Because the lock latency is a fixed 3 cycles, the difference is visible at the exact cycle the flag rises. A wrong or wrapping idle counter moves the drop of the flag away from cycle T+4 after the last edge. It can also make a run fail to restart after a gap of T+1, which shows as an early lock within N edges. A power-down that is not fully cleared leaves the flag high one cycle after assertion, or lets the relock after release come in fewer than N edges.

// File: rtl/de_act_pkg.sv
package de_act_pkg;

  // Width needed to hold values 0..max_val.
  function automatic int unsigned ctr_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Idle counter step: restart on activity, otherwise count up and stick at lim.
  function automatic int unsigned idle_step(input int unsigned cur,
                                            input int unsigned lim,
                                            input bit          activity);
    if (activity)      return 0;
    else if (cur >= lim) return lim;
    else               return cur + 1;
  endfunction

  // Rising-edge run counter step: a stale window restarts the run.
  function automatic int unsigned run_step(input int unsigned cur,
                                           input int unsigned goal,
                                           input bit          rise,
                                           input bit          stale);
    if (stale)         return rise ? 1 : 0;
    else if (!rise)    return cur;
    else if (cur >= goal) return goal;
    else               return cur + 1;
  endfunction

endpackage

// File: rtl/de_sync_chain.sv
module de_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/de_edge_timer.sv
module de_edge_timer
  import de_act_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 165000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic de_s,
  output logic rise_o,
  output logic timeout_o
);
  localparam int unsigned IW    = ctr_width(TIMEOUT_CYCLES);
  localparam logic [IW-1:0] LIMIT = IW'(TIMEOUT_CYCLES);

  logic          de_d;
  logic [IW-1:0] idle_q;
  logic          edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) de_d <= 1'b0;
    else        de_d <= de_s;
  end

  assign edge_w    = de_s ^ de_d;
  assign rise_o    = de_s & ~de_d;
  assign timeout_o = (idle_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idle_q <= '0;
    else if (clear) idle_q <= '0;
    else            idle_q <= IW'(idle_step(32'(idle_q), TIMEOUT_CYCLES, edge_w));
  end

  // R6: counter never passes its limit
  p_idle_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= LIMIT);
  // R6: a reached limit is held while the line stays quiet
  p_idle_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !edge_w && !clear) |=> timeout_o);
  // R8: any edge, falling included, restarts the idle count
  p_edge_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && !clear) |=> (idle_q == '0));
  // R7: power-down empties the idle count
  p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idle_q == '0));
endmodule

// File: rtl/de_lock_ctrl.sv
module de_lock_ctrl
  import de_act_pkg::*;
#(
  parameter int unsigned EDGES_TO_LOCK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic rise_i,
  input  logic stale_i,
  output logic alive_o
);
  localparam int unsigned CW   = ctr_width(EDGES_TO_LOCK);
  localparam logic [CW-1:0] GOAL = CW'(EDGES_TO_LOCK);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          lock_set;

  assign cnt_d    = CW'(run_step(32'(cnt_q), EDGES_TO_LOCK, rise_i, stale_i));
  assign lock_set = rise_i && (cnt_d == GOAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alive_o <= 1'b0;
    end else if (clear) begin
      cnt_q   <= '0;
      alive_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (lock_set)     alive_o <= 1'b1;
      else if (stale_i) alive_o <= 1'b0;
    end
  end

  // R2: the flag only rises on a counted rising edge
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alive_o) |-> $past(rise_i));
  // R4: a rising edge after an expired window starts a new run
  p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && stale_i && !clear) |=> (cnt_q == CW'(1)));
  // R5: an expired window with no rising edge drops the flag
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_i && !rise_i && !clear) |=> !alive_o);
  // R7: power-down clears flag and run count
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!alive_o && cnt_q == '0));
  // R8: a live link with no expired window stays live
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_o && !stale_i && !clear) |=> alive_o);
endmodule

// File: rtl/link_activity_detector.sv
module link_activity_detector #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned EDGES_TO_LOCK  = 4,
  parameter int unsigned TIMEOUT_CYCLES = 165000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic de_in,
  output logic link_alive
);
  logic de_sync;
  logic de_rise;
  logic de_stale;

  de_sync_chain #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (de_in),
    .dout (de_sync)
  );

  de_edge_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pwr_down),
    .de_s     (de_sync),
    .rise_o   (de_rise),
    .timeout_o(de_stale)
  );

  de_lock_ctrl #(.EDGES_TO_LOCK(EDGES_TO_LOCK)) lock_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (pwr_down),
    .rise_i (de_rise),
    .stale_i(de_stale),
    .alive_o(link_alive)
  );

  // R1: flag is low in reset
  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (!link_alive);
  end
endmodule

// File: tb/link_activity_detector_tb_top.sv
`timescale 1ns/1ps
module link_activity_detector_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned T = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_down;
  logic de_in;
  logic link_alive;
  int   vectors = 0;
  int   fails   = 0;

  always #2 clk = ~clk;

  link_activity_detector #(
    .SYNC_STAGES(2), .EDGES_TO_LOCK(N), .TIMEOUT_CYCLES(T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .de_in(de_in), .link_alive(link_alive)
  );

  task automatic chk(input logic exp, input string tag);
    vectors++;
    if (link_alive !== exp) begin
      fails++;
      $display("FAIL %s: link_alive=%b expected=%b at %0t", tag, link_alive, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_chk(input int n, input logic exp, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(exp, tag);
    end
  endtask

  task automatic pulses(input int n, input int hi, input int lo,
                        input bit do_chk, input logic exp, input string tag);
    for (int i = 0; i < n; i++) begin
      de_in = 1'b1;
      if (do_chk) step_chk(hi, exp, tag); else step(hi);
      de_in = 1'b0;
      if (do_chk) step_chk(lo, exp, tag); else step(lo);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_down = 1'b0; de_in = 1'b0;
    step(3);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    step_chk(4, 1'b0, "R1 after reset");

    // R2: lock on the N-th rising edge, 3 cycles after it
    pulses(N-1, 2, 2, 1'b1, 1'b0, "R2 before N-th rise");
    de_in = 1'b1; step(2);
    chk(1'b0, "R2 lock not at 2 cycles");
    step(1);
    chk(1'b1, "R2 lock at 3 cycles");
    step(1); de_in = 1'b0; step(2);
    pulses(5, 2, 2, 1'b1, 1'b1, "R2 stays locked while toggling");

    // R5: drop T+4 cycles after a last falling edge
    de_in = 1'b1; step(2);
    de_in = 1'b0;
    step_chk(T+3, 1'b1, "R5 held during timeout (low)");
    step(1);
    chk(1'b0, "R5 dropped at T+4 (low)");

    // R6: long static line keeps flag low
    step_chk(4*T, 1'b0, "R6 long static");

    // R3: too few rises
    pulses(N-1, 2, 2, 1'b1, 1'b0, "R3 short run");
    step_chk(T+8, 1'b0, "R3 short run then static");

    // R4: gap of T+1 restarts the run
    pulses(N-2, 2, 2, 1'b0, 1'b0, "");
    de_in = 1'b1; step(2);
    de_in = 1'b0; step(T+1);
    de_in = 1'b1;
    step_chk(3, 1'b0, "R4 gap T+1 restarts run");
    de_in = 1'b0; step(2);
    pulses(N-2, 2, 2, 1'b1, 1'b0, "R4 rebuilding run");
    de_in = 1'b1; step(2);
    chk(1'b0, "R4 relock not at 2 cycles");
    step(1);
    chk(1'b1, "R4 relock after N fresh rises");

    // R4: gap of exactly T keeps the run
    step(1); de_in = 1'b0;
    step(T+6);
    chk(1'b0, "R4 setup unlocked");
    pulses(N-2, 2, 2, 1'b0, 1'b0, "");
    de_in = 1'b1; step(2);
    de_in = 1'b0; step(T);
    de_in = 1'b1; step(2);
    chk(1'b0, "R4 gap T not at 2 cycles");
    step(1);
    chk(1'b1, "R4 gap T continues run");

    // R8: falling edges keep a slow waveform alive
    de_in = 1'b0;
    step_chk(15, 1'b1, "R8 slow waveform");
    pulses(4, 15, 15, 1'b1, 1'b1, "R8 slow waveform");

    // R5: drop after a last rising edge (stuck high)
    de_in = 1'b1;
    step_chk(T+3, 1'b1, "R5 held during timeout (high)");
    step(1);
    chk(1'b0, "R5 dropped at T+4 (high)");

    // R7: power-down clears and forces a full relock
    de_in = 1'b0; step(2);
    pulses(N-1, 2, 2, 1'b0, 1'b0, "");
    de_in = 1'b1; step(3);
    chk(1'b1, "R7 setup locked");
    step(1); de_in = 1'b0; step(1);
    pwr_down = 1'b1;
    step(1);
    chk(1'b0, "R7 cleared one cycle after power-down");
    pulses(N+1, 2, 2, 1'b1, 1'b0, "R7 rises ignored in power-down");
    step(3);
    pwr_down = 1'b0;
    step(2);
    pulses(N-1, 2, 2, 1'b1, 1'b0, "R7 relock needs N rises");
    de_in = 1'b1; step(2);
    chk(1'b0, "R7 relock not at 2 cycles");
    step(1);
    chk(1'b1, "R7 relock after N fresh rises");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule